// File: doc/BRIEF.md
# Flash programmer-mode access and protection front end

This block is the parallel programmer-side front end of a byte-wide flash array. The array holds 8 equal 64 KB sectors, and a byte address is 19 bits wide. The host presents that address in two halves on a shared 11-bit bus. While the row/column select is high, the bus carries the upper 8 address bits. While it is low, the bus carries the lower 11 bits. Write-enable and output-enable strobes mark each half.

Host writes pass through a command decoder, which recognises four kinds of sequence:
- byte program;
- sector erase;
- entry into identification mode;
- exit from identification mode.

Accepted program, erase and read operations go to an external array port over a request/acknowledge handshake.

Two active-low protection pins and the interface-mode pin are latched only while reset is held. One protection pin guards the top (boot) sector. The other guards the remaining seven sectors. A program or erase that targets a guarded sector is dropped and raises a sticky blocked flag. In identification mode, a read at one fixed address returns the inverted latched protection pins, and the array is not accessed.

Top module: `flash_pgm_front`

## Requirements
- R1: The array address is {row, column}. The row is the low 8 bits of `addr` taken while `rc_sel`=1 and a strobe (`we_n` or `oe_n`) is low. It forms bits 18:11. The column is `addr[10:0]` taken with `rc_sel`=0 and forms bits 10:0.
- R2: `dq_en` is 1 only while `oe_n` is 0, reset is high and programmer mode is latched. An array read starts when `oe_n` falls with `rc_sel`=0 and `we_n`=1. `dq_out` then shows the acknowledged `arr_rdata`.
- R3: A command write completes on a rising `we_n` with `rc_sel`=0. The sequence 0xAA@0x05555, 0x55@0x02AAA, 0xA0@0x05555, then data D at address A, issues one request with `arr_op`=01, `arr_addr`=A and `arr_wdata`=D.
- R4: The sequence 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, then 0x30 at any address A, issues one request with `arr_op`=10 and `arr_addr`=A.
- R5: If `tbl_n` is 0 while reset is low, every program or erase to sector 7 (address bits 18:16 = 7) is dropped with no request and sets `prot_hit`. A later change of the pin has no effect until the next reset.
- R6: If `wp_n` is 0 while reset is low, every program or erase to sectors 0 to 6 is dropped with no request and sets `prot_hit`. Sector 7 stays writable.
- R7: The sequence 0xAA@0x05555, 0x55@0x02AAA, 0x90@0x05555 enters identification mode. In that mode a read at 0x7FFF2 (row 0xFF, column 0x7F2) returns bit 2 = NOT latched `tbl_n` and bit 3 = NOT latched `wp_n`, with all other bits 0. No array read is issued.
- R8: Identification mode is left by 0xAA@0x05555, 0x55@0x02AAA, 0xF0@0x05555, or by a single 0xF0 write to any address. Reads then go to the array again.
- R9: A write that does not match the next expected step of a sequence returns the decoder to idle. No request follows from the broken sequence.
- R10: If `mode_pgm` is 0 while reset is low, the block stays idle until the next reset. It issues no array request and never drives `dq_en`.
- R11: While `rst_n` is 0, `dq_en` and `arr_req` are 0 and `prot_hit` is cleared.
- R12: `arr_req` stays high with stable `arr_op`, `arr_addr` and `arr_wdata` until `arr_ack`. It then drops, and each accepted operation produces exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; pins latched while low |
| mode_pgm | input | 1 | Interface mode select, 1 = programmer mode |
| tbl_n | input | 1 | Boot sector lock, active low |
| wp_n | input | 1 | Lock of sectors 0 to 6, active low |
| addr | input | 11 | Multiplexed row/column address |
| rc_sel | input | 1 | 1 = row phase, 0 = column phase |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_in | input | 8 | Write data from host |
| dq_out | output | 8 | Read data to host |
| dq_en | output | 1 | Data bus drive enable (0 = high impedance) |
| arr_req | output | 1 | Array operation request |
| arr_op | output | 2 | 00 read, 01 program, 10 erase |
| arr_addr | output | 19 | Array byte address |
| arr_wdata | output | 8 | Program data |
| arr_ack | input | 1 | Array operation acknowledge |
| arr_rdata | input | 8 | Array read data, valid with ack |
| prot_hit | output | 1 | Sticky flag: a protected program/erase was dropped |

## Verification
A wrong decoder state shows on the array port within a few cycles of the completing `we_n` rise. It appears as a missing request, an extra request, or a request with the wrong op code. A wrong latched lock value shows up twice: in the identification byte, and in whether `prot_hit` rises or a request appears after a program to a chosen sector. A bad row or column latch shows up as a wrong `arr_addr` on the next request, or as a wrong identification byte because the magic address was missed.

// File: rtl/flash_pgm_front.sv
module flash_pgm_front #(
  parameter int AW   = 19,
  parameter int CW   = 11,
  parameter int DW   = 8,
  parameter int SECW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_pgm,
  input  logic          tbl_n,
  input  logic          wp_n,
  input  logic [CW-1:0] addr,
  input  logic          rc_sel,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_en,
  output logic          arr_req,
  output logic [1:0]    arr_op,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  input  logic          arr_ack,
  input  logic [DW-1:0] arr_rdata,
  output logic          prot_hit
);
  localparam int RW = AW - CW;
  localparam logic [1:0] OP_RD = 2'b00, OP_PG = 2'b01, OP_ER = 2'b10;
  localparam logic [AW-1:0] A_HI = 19'h05555, A_LO = 19'h02AAA, ID_ADDR = 19'h7FFF2;
  localparam logic [DW-1:0] C_AA = 8'hAA, C_55 = 8'h55, C_A0 = 8'hA0, C_80 = 8'h80,
                            C_90 = 8'h90, C_F0 = 8'hF0, C_30 = 8'h30;

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PRG, S_E1, S_E2, S_E3} st_t;

  st_t           st;
  logic          pgm_lat, tbl_lat, wp_lat;
  logic          we_q, oe_q, ident;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [DW-1:0] dat_q, rd_q;

  wire           port_free = ~arr_req;
  wire           we_rise   = pgm_lat & we_n & ~we_q & ~rc_sel;
  wire           oe_fall   = pgm_lat & ~oe_n & oe_q & we_n & we_q & ~rc_sel;
  wire [AW-1:0]  wa        = {row_q, col_q};
  wire [AW-1:0]  ra        = {row_q, addr};
  wire [SECW-1:0] wsec     = wa[AW-1 -: SECW];
  wire           locked    = (&wsec) ? ~tbl_lat : ~wp_lat;
  wire [DW-1:0]  id_byte   = {{(DW-4){1'b0}}, ~wp_lat, ~tbl_lat, 2'b00};

  assign dq_en  = rst_n & pgm_lat & ~oe_n;
  assign dq_out = dq_en ? rd_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pgm_lat   <= mode_pgm;
      tbl_lat   <= tbl_n;
      wp_lat    <= wp_n;
      we_q      <= 1'b1;
      oe_q      <= 1'b1;
      row_q     <= '0;
      col_q     <= '0;
      dat_q     <= '0;
      rd_q      <= '0;
      st        <= S_IDLE;
      ident     <= 1'b0;
      arr_req   <= 1'b0;
      arr_op    <= OP_RD;
      arr_addr  <= '0;
      arr_wdata <= '0;
      prot_hit  <= 1'b0;
    end else begin
      we_q <= we_n;
      oe_q <= oe_n;
      if (pgm_lat) begin
        if (rc_sel && (!we_n || !oe_n)) row_q <= addr[RW-1:0];
        if (!rc_sel && !we_n) begin
          col_q <= addr;
          dat_q <= dq_in;
        end
      end

      if (arr_req && arr_ack) begin
        arr_req <= 1'b0;
        if (arr_op == OP_RD) rd_q <= arr_rdata;
      end

      if (oe_fall && port_free) begin
        if (ident) rd_q <= (ra == ID_ADDR) ? id_byte : '0;
        else begin
          arr_req  <= 1'b1;
          arr_op   <= OP_RD;
          arr_addr <= ra;
        end
      end

      if (we_rise && port_free) begin
        if (dat_q == C_F0 && st != S_PRG) begin
          ident <= 1'b0;
          st    <= S_IDLE;
        end else begin
          st <= S_IDLE;
          case (st)
            S_IDLE: if (dat_q == C_AA && wa == A_HI) st <= S_U1;
            S_U1:   if (dat_q == C_55 && wa == A_LO) st <= S_U2;
            S_U2: if (wa == A_HI) begin
              if (dat_q == C_90) ident <= 1'b1;
              if (dat_q == C_A0) st <= S_PRG;
              if (dat_q == C_80) st <= S_E1;
            end
            S_PRG: begin
              if (locked) prot_hit <= 1'b1;
              else begin
                arr_req   <= 1'b1;
                arr_op    <= OP_PG;
                arr_addr  <= wa;
                arr_wdata <= dat_q;
              end
            end
            S_E1: if (dat_q == C_AA && wa == A_HI) st <= S_E2;
            S_E2: if (dat_q == C_55 && wa == A_LO) st <= S_E3;
            S_E3: if (dat_q == C_30) begin
              if (locked) prot_hit <= 1'b1;
              else begin
                arr_req  <= 1'b1;
                arr_op   <= OP_ER;
                arr_addr <= wa;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/flash_pgm_front_chk.sv
module flash_pgm_front_chk #(
  parameter int AW   = 19,
  parameter int DW   = 8,
  parameter int SECW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oe_n,
  input logic          dq_en,
  input logic          arr_req,
  input logic          arr_ack,
  input logic [1:0]    arr_op,
  input logic [AW-1:0] arr_addr,
  input logic [DW-1:0] arr_wdata,
  input logic          prot_hit,
  input logic          pgm_lat,
  input logic          tbl_lat,
  input logic          wp_lat
);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && !arr_ack |=> arr_req && $stable(arr_addr) && $stable(arr_op) && $stable(arr_wdata));

  a_r5_boot_guard: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && arr_op != 2'b00 && (&arr_addr[AW-1 -: SECW]) |-> tbl_lat);

  a_r6_wp_guard: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && arr_op != 2'b00 && !(&arr_addr[AW-1 -: SECW]) |-> wp_lat);

  a_r11_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    prot_hit |=> prot_hit);

  a_r10_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_lat |-> !arr_req && !dq_en);

  a_r2_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_en);

  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !dq_en);
endmodule

bind flash_pgm_front flash_pgm_front_chk #(.AW(AW), .DW(DW), .SECW(SECW)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dq_en(dq_en), .arr_req(arr_req),
  .arr_ack(arr_ack), .arr_op(arr_op), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
  .prot_hit(prot_hit), .pgm_lat(pgm_lat), .tbl_lat(tbl_lat), .wp_lat(wp_lat)
);

// File: tb/flash_pgm_front_bench.sv
`timescale 1ns/1ps
module flash_pgm_front_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, mode_pgm = 1'b1, tbl_n = 1'b1, wp_n = 1'b1;
  logic [10:0] addr = '0;
  logic        rc_sel = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out, arr_wdata, arr_rdata;
  logic        dq_en, arr_req, arr_ack, prot_hit;
  logic [1:0]  arr_op;
  logic [18:0] arr_addr;

  flash_pgm_front u_flash_pgm_front (
    .clk(clk), .rst_n(rst_n), .mode_pgm(mode_pgm), .tbl_n(tbl_n), .wp_n(wp_n),
    .addr(addr), .rc_sel(rc_sel), .we_n(we_n), .oe_n(oe_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_en(dq_en), .arr_req(arr_req), .arr_op(arr_op),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_ack(arr_ack),
    .arr_rdata(arr_rdata), .prot_hit(prot_hit)
  );

  int n_rd, n_pg, n_er, wcnt;
  logic [1:0]  last_op;
  logic [18:0] last_addr;
  logic [7:0]  last_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      arr_ack <= 1'b0; wcnt <= 0; arr_rdata <= '0;
    end else if (arr_ack) arr_ack <= 1'b0;
    else if (arr_req) begin
      if (wcnt == 2) begin
        arr_ack   <= 1'b1;
        wcnt      <= 0;
        arr_rdata <= arr_addr[7:0] ^ arr_addr[15:8];
        last_op   <= arr_op;
        last_addr <= arr_addr;
        last_data <= arr_wdata;
        if (arr_op == 2'b00) n_rd <= n_rd + 1;
        if (arr_op == 2'b01) n_pg <= n_pg + 1;
        if (arr_op == 2'b10) n_er <= n_er + 1;
      end else wcnt <= wcnt + 1;
    end
  end

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] model_rd(input logic [7:0] row, input logic [10:0] col);
    logic [18:0] a;
    a = {row, col};
    return a[7:0] ^ a[15:8];
  endfunction

  task automatic do_reset(input logic m, input logic t, input logic w);
    @(negedge clk);
    rst_n = 1'b0; mode_pgm = m; tbl_n = t; wp_n = w;
    we_n = 1'b1; oe_n = 1'b1; rc_sel = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    mode_pgm = ~m; tbl_n = ~t; wp_n = ~w;
    tick(1);
  endtask

  task automatic wr(input logic [7:0] row, input logic [10:0] col, input logic [7:0] d);
    rc_sel = 1'b1; addr = {3'b000, row}; we_n = 1'b0; tick(1);
    we_n = 1'b1; tick(1);
    rc_sel = 1'b0; addr = col; dq_in = d; we_n = 1'b0; tick(1);
    we_n = 1'b1; tick(6);
  endtask

  task automatic unlock();
    wr(8'h0A, 11'h555, 8'hAA);
    wr(8'h05, 11'h2AA, 8'h55);
  endtask

  task automatic rd(input logic [7:0] row, input logic [10:0] col, output logic [7:0] d, output logic en);
    rc_sel = 1'b1; addr = {3'b000, row}; oe_n = 1'b0; tick(1);
    oe_n = 1'b1; tick(1);
    rc_sel = 1'b0; addr = col; oe_n = 1'b0; tick(8);
    d = dq_out; en = dq_en;
    oe_n = 1'b1; tick(2);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; oe_n = 1'b0; tick(2);
    check(dq_en == 1'b0, "R11 dq_en low in reset", dq_en, 0);
    check(arr_req == 1'b0, "R11 no request in reset", arr_req, 0);
    check(prot_hit == 1'b0, "R11 flag clear in reset", prot_hit, 0);
    oe_n = 1'b1;
    do_reset(1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_read();
    logic [7:0] d; logic en; int r0;
    r0 = n_rd;
    rd(8'h12, 11'h345, d, en);
    check(en == 1'b1, "R2 dq_en while oe_n low", en, 1);
    check(d == model_rd(8'h12, 11'h345), "R1 read data at row/col address", d, model_rd(8'h12, 11'h345));
    check(dq_en == 1'b0, "R2 high impedance after oe_n high", dq_en, 0);
    check(n_rd == r0 + 1, "R12 one read request", n_rd, r0 + 1);
    rd(8'hC3, 11'h07E, d, en);
    check(d == model_rd(8'hC3, 11'h07E), "R1 second read address", d, model_rd(8'hC3, 11'h07E));
  endtask

  task automatic t_program();
    int p0;
    p0 = n_pg;
    unlock(); wr(8'h0A, 11'h555, 8'hA0);
    wr(8'h33, 11'h123, 8'h5C);
    check(n_pg == p0 + 1, "R3 one program request", n_pg, p0 + 1);
    check(last_op == 2'b01, "R3 program op code", last_op, 1);
    check(last_addr == {8'h33, 11'h123}, "R1 program address", last_addr, {8'h33, 11'h123});
    check(last_data == 8'h5C, "R3 program data", last_data, 8'h5C);
    check(arr_req == 1'b0, "R12 request dropped after ack", arr_req, 0);
  endtask

  task automatic t_erase();
    int e0;
    e0 = n_er;
    unlock(); wr(8'h0A, 11'h555, 8'h80);
    unlock(); wr(8'h25, 11'h010, 8'h30);
    check(n_er == e0 + 1, "R4 one erase request", n_er, e0 + 1);
    check(last_op == 2'b10, "R4 erase op code", last_op, 2);
    check(last_addr == {8'h25, 11'h010}, "R4 erase address", last_addr, {8'h25, 11'h010});
  endtask

  task automatic t_broken();
    int p0, e0;
    p0 = n_pg; e0 = n_er;
    wr(8'h0A, 11'h555, 8'hAA);
    wr(8'h05, 11'h2AB, 8'h55);
    wr(8'h0A, 11'h555, 8'hA0);
    wr(8'h11, 11'h011, 8'h77);
    check(n_pg == p0, "R9 bad address breaks program sequence", n_pg, p0);
    unlock(); wr(8'h0A, 11'h555, 8'h80);
    wr(8'h0A, 11'h555, 8'h12);
    wr(8'h05, 11'h2AA, 8'h55);
    wr(8'h21, 11'h000, 8'h30);
    check(n_er == e0, "R9 bad data breaks erase sequence", n_er, e0);
  endtask

  task automatic t_ident(input logic [7:0] exp_id);
    logic [7:0] d; logic en; int r0;
    unlock(); wr(8'h0A, 11'h555, 8'h90);
    r0 = n_rd;
    rd(8'hFF, 11'h7F2, d, en);
    check(d == exp_id, "R7 identification byte", d, exp_id);
    check(n_rd == r0, "R7 no array read in identification", n_rd, r0);
    unlock(); wr(8'h0A, 11'h555, 8'hF0);
    rd(8'h12, 11'h345, d, en);
    check(d == model_rd(8'h12, 11'h345) && n_rd == r0 + 1, "R8 three-byte exit", d, model_rd(8'h12, 11'h345));
    unlock(); wr(8'h0A, 11'h555, 8'h90);
    wr(8'h40, 11'h001, 8'hF0);
    rd(8'h2B, 11'h100, d, en);
    check(d == model_rd(8'h2B, 11'h100), "R8 single-byte exit", d, model_rd(8'h2B, 11'h100));
  endtask

  task automatic t_boot_lock();
    int p0;
    do_reset(1'b1, 1'b0, 1'b1);
    t_ident(8'h04);
    p0 = n_pg;
    unlock(); wr(8'h0A, 11'h555, 8'hA0); wr(8'hE0, 11'h000, 8'h11);
    check(n_pg == p0, "R5 boot sector program dropped", n_pg, p0);
    check(prot_hit == 1'b1, "R5 blocked flag set", prot_hit, 1);
    unlock(); wr(8'h0A, 11'h555, 8'hA0); wr(8'h40, 11'h003, 8'h22);
    check(n_pg == p0 + 1, "R5 other sector still writable", n_pg, p0 + 1);
  endtask

  task automatic t_wp_lock();
    int p0, e0;
    do_reset(1'b1, 1'b1, 1'b0);
    check(prot_hit == 1'b0, "R11 reset clears blocked flag", prot_hit, 0);
    t_ident(8'h08);
    p0 = n_pg; e0 = n_er;
    unlock(); wr(8'h0A, 11'h555, 8'hA0); wr(8'h60, 11'h004, 8'h33);
    check(n_pg == p0 && prot_hit == 1'b1, "R6 sector 3 program dropped", n_pg, p0);
    unlock(); wr(8'h0A, 11'h555, 8'h80);
    unlock(); wr(8'hF1, 11'h000, 8'h30);
    check(n_er == e0 + 1, "R6 boot sector erase allowed", n_er, e0 + 1);
  endtask

  task automatic t_mode();
    logic [7:0] d; logic en; int r0, p0;
    do_reset(1'b0, 1'b1, 1'b1);
    r0 = n_rd; p0 = n_pg;
    rd(8'h12, 11'h345, d, en);
    check(en == 1'b0 && n_rd == r0, "R10 no read in other mode", en, 0);
    unlock(); wr(8'h0A, 11'h555, 8'hA0); wr(8'h33, 11'h123, 8'h5C);
    check(n_pg == p0, "R10 no program in other mode", n_pg, p0);
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    n_rd = 0; n_pg = 0; n_er = 0;
    last_op = '0; last_addr = '0; last_data = '0;
    do_reset(1'b1, 1'b1, 1'b1);
    t_reset();
    t_read();
    t_program();
    t_erase();
    t_broken();
    t_ident(8'h00);
    t_boot_lock();
    t_wp_lock();
    t_mode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule